// File: doc/BRIEF.md
# Dirty-Page Snapshot Copier

This block keeps a read-only shadow copy of a working memory in step with it. Producers write 32-bit words into the working memory. Each accepted write sets the bit for its page in a packed dirty bitmap. A consumer reads the shadow copy, which changes only during a sync. When a sync is requested, a copy engine walks the bitmap and moves only the dirty pages into the shadow, one word per cycle. It clears the bitmap as it goes and then reports the number of bytes it moved.

A whole-region mode copies everything and wipes the bitmap. It is meant for bring-up, or for when the shadow has to be rebuilt. Working-memory writes are held off while a sync runs, so no dirty mark can be lost between a scan and its clear. Addresses at both memory ports are word addresses. The byte address of a word is four times its word address.

Top module: `snap_copier`

## Requirements
- R1: After reset the block is idle: `wr_ready`=1, `sync_busy`=0, `done_pulse`=0, `done_bytes`=0, and the dirty bitmap is empty, so a first incremental sync reports 0 bytes.
- R2: A write is accepted on a clock edge where `wr_en` and `wr_ready` are both high. It marks page p = byte address >> PAGE_SHIFT, which is bit p & 7 of bitmap byte p >> 3. Further writes to an already marked page do not add to the count.
- R3: An incremental sync checks the bitmap bytes from index 0 upward and the bits from LSB to MSB. For every marked page it copies that page plus the following 4 bytes, so each page counts PAGE_BYTES+4. The last page of the region counts exactly PAGE_BYTES. The shadow then holds the written data.
- R4: A bitmap byte of zero is passed over as a whole, and the byte count starts at 0 for each sync.
- R5: A sync with an empty bitmap completes and reports 0 bytes.
- R6: After an incremental sync the bitmap is empty, so an immediate second incremental sync reports 0.
- R7: With `sync_whole`=1 the whole region is copied, the reported count equals the region size in bytes, and the bitmap is cleared.
- R8: While a sync runs, `wr_ready` is 0. A pending write is held and is accepted only after the sync has finished, and it marks its page for the next sync. The byte count advances in steps of 4 bytes, one per word copied.
- R9: A `sync_req` seen while a sync is already running is ignored and produces no extra completion.
- R10: `done_pulse` is high for exactly one cycle per sync, in the first idle cycle after `sync_busy` falls. `done_bytes` changes only in that cycle and holds its value until the next completion.
- R11: The shadow read port returns the word at `sh_rd_word_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Working-memory write request |
| wr_word_addr | input | ADDR_W-2 | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Write may be accepted this cycle |
| sync_req | input | 1 | Start a sync (taken only when idle) |
| sync_whole | input | 1 | With `sync_req`: copy the whole region |
| sync_busy | output | 1 | Sync in progress |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_bytes | output | CNT_W | Bytes copied by the last sync |
| sh_rd_word_addr | input | ADDR_W-2 | Shadow read word address |
| sh_rd_data | output | 32 | Shadow read data, one cycle later |

## Verification
The bench builds the block with ADDR_W=8 and PAGE_SHIFT=4. This gives sixteen 16-byte pages spread over two bitmap bytes, so a dirty page costs 20 bytes and the final page costs 16. With this small geometry the crossing from one bitmap byte to the next and the missing overlap on the last page both come up within a few hundred cycles. A fully dirty map, which takes 316 bytes, is long enough to stall a write and to drop a second request in mid-sync.

// File: rtl/snap_pkg.sv
package snap_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_BITS,
        ST_COPY,
        ST_FINISH
    } eng_state_e;
endpackage

// File: rtl/snap_ram.sv
module snap_ram #(
    parameter int AW = 11,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/snap_dirty_map.sv
module snap_dirty_map #(
    parameter int PG_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [PG_W-1:0] set_page,
    input  logic            clr_byte_en,
    input  logic [((PG_W > 3) ? PG_W-3 : 1)-1:0] clr_idx,
    input  logic            clr_all,
    input  logic [((PG_W > 3) ? PG_W-3 : 1)-1:0] rd_idx,
    output logic [7:0]      rd_byte
);
    localparam int MI_W      = (PG_W > 3) ? PG_W - 3 : 1;
    localparam int MAP_BYTES = 1 << (PG_W - 3);

    logic [7:0] map_d [MAP_BYTES];
    logic [7:0] map_q [MAP_BYTES];
    logic [MI_W-1:0] set_byte;
    logic [2:0]      set_bit;

    assign set_byte = MI_W'(set_page >> 3);
    assign set_bit  = set_page[2:0];

    always_comb begin
        for (int i = 0; i < MAP_BYTES; i++) map_d[i] = map_q[i];
        if (set_en)      map_d[set_byte][set_bit] = 1'b1;
        if (clr_byte_en) map_d[clr_idx] = 8'h00;
        if (clr_all) begin
            for (int i = 0; i < MAP_BYTES; i++) map_d[i] = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAP_BYTES; i++) map_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < MAP_BYTES; i++) map_q[i] <= map_d[i];
        end
    end

    assign rd_byte = map_q[rd_idx];
endmodule

// File: rtl/snap_copy_engine.sv
module snap_copy_engine
    import snap_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PAGE_SHIFT = 10,
    parameter int CNT_W      = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_req,
    input  logic            sync_whole,
    input  logic [7:0]      map_byte,
    output logic [((ADDR_W-PAGE_SHIFT > 3) ? ADDR_W-PAGE_SHIFT-3 : 1)-1:0] map_idx,
    output logic            clr_byte_en,
    output logic            clr_all,
    output logic [ADDR_W-3:0] rd_addr,
    output logic            sh_we,
    output logic [ADDR_W-3:0] sh_addr,
    output logic            busy,
    output logic            done,
    output logic [CNT_W-1:0] done_bytes
);
    localparam int WA_W      = ADDR_W - 2;
    localparam int PG_W      = ADDR_W - PAGE_SHIFT;
    localparam int WPP_SH    = PAGE_SHIFT - 2;
    localparam int MI_W      = (PG_W > 3) ? PG_W - 3 : 1;
    localparam int MAP_BYTES = 1 << (PG_W - 3);
    localparam logic [MI_W-1:0] LAST_BYTE = MI_W'(MAP_BYTES - 1);
    localparam logic [PG_W-1:0] LAST_PAGE = '1;

    typedef struct packed {
        eng_state_e       st;
        logic [MI_W-1:0]  byte_idx;
        logic [2:0]       bit_idx;
        logic [WA_W-1:0]  word;
        logic [WA_W-1:0]  last;
        logic             whole;
        logic             pend_v;
        logic [WA_W-1:0]  pend_a;
        logic [CNT_W-1:0] bytes;
        logic             done;
        logic [CNT_W-1:0] done_bytes;
    } eng_t;

    eng_t r_q, r_d;

    logic [PG_W-1:0]  cur_page;
    logic [WA_W-1:0]  page_first;
    logic [WA_W-1:0]  page_end;
    logic [WA_W-1:0]  copy_last;
    eng_state_e       adv_st;
    logic [MI_W-1:0]  adv_byte;
    logic [2:0]       adv_bit;
    logic             adv_clr;

    assign cur_page   = PG_W'({r_q.byte_idx, r_q.bit_idx});
    assign page_first = {cur_page, {WPP_SH{1'b0}}};
    assign page_end   = {cur_page, {WPP_SH{1'b1}}};
    // one overlap word past every page except the region's final one
    assign copy_last  = (cur_page == LAST_PAGE) ? page_end : page_end + 1'b1;

    // where the walk goes once the current bit has been handled
    always_comb begin
        if (r_q.bit_idx == 3'd7) begin
            adv_clr  = 1'b1;
            adv_bit  = 3'd0;
            adv_byte = MI_W'(r_q.byte_idx + 1'b1);
            adv_st   = (r_q.byte_idx == LAST_BYTE) ? ST_FINISH : ST_SCAN;
        end else begin
            adv_clr  = 1'b0;
            adv_bit  = r_q.bit_idx + 3'd1;
            adv_byte = r_q.byte_idx;
            adv_st   = ST_BITS;
        end
    end

    always_comb begin
        r_d         = r_q;
        r_d.pend_v  = 1'b0;
        r_d.done    = 1'b0;
        clr_byte_en = 1'b0;
        clr_all     = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sync_req) begin
                    r_d.whole    = sync_whole;
                    r_d.bytes    = '0;
                    r_d.byte_idx = '0;
                    r_d.bit_idx  = 3'd0;
                    if (sync_whole) begin
                        r_d.st   = ST_COPY;
                        r_d.word = '0;
                        r_d.last = '1;
                        clr_all  = 1'b1;
                    end else begin
                        r_d.st = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (map_byte == 8'h00) begin
                    if (r_q.byte_idx == LAST_BYTE) r_d.st = ST_FINISH;
                    else r_d.byte_idx = MI_W'(r_q.byte_idx + 1'b1);
                end else begin
                    r_d.st      = ST_BITS;
                    r_d.bit_idx = 3'd0;
                end
            end
            ST_BITS: begin
                if (map_byte[r_q.bit_idx]) begin
                    r_d.st   = ST_COPY;
                    r_d.word = page_first;
                    r_d.last = copy_last;
                end else begin
                    r_d.st       = adv_st;
                    r_d.byte_idx = adv_byte;
                    r_d.bit_idx  = adv_bit;
                    clr_byte_en  = adv_clr;
                end
            end
            ST_COPY: begin
                r_d.pend_v = 1'b1;
                r_d.pend_a = r_q.word;
                r_d.bytes  = r_q.bytes + CNT_W'(4);
                if (r_q.word == r_q.last) begin
                    if (r_q.whole) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.st       = adv_st;
                        r_d.byte_idx = adv_byte;
                        r_d.bit_idx  = adv_bit;
                        clr_byte_en  = adv_clr;
                    end
                end else begin
                    r_d.word = r_q.word + 1'b1;
                end
            end
            ST_FINISH: begin
                r_d.done       = 1'b1;
                r_d.done_bytes = r_q.bytes;
                r_d.st         = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign map_idx    = r_q.byte_idx;
    assign rd_addr    = r_q.word;
    assign sh_we      = r_q.pend_v;
    assign sh_addr    = r_q.pend_a;
    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign done_bytes = r_q.done_bytes;
endmodule

// File: rtl/snap_copier.sv
module snap_copier
    import snap_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PAGE_SHIFT = 10,
    parameter int CNT_W      = $clog2((1 << ADDR_W) + 4 * (1 << (ADDR_W - PAGE_SHIFT)) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-3:0]   wr_word_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                wr_ready,
    input  logic                sync_req,
    input  logic                sync_whole,
    output logic                sync_busy,
    output logic                done_pulse,
    output logic [CNT_W-1:0]    done_bytes,
    input  logic [ADDR_W-3:0]   sh_rd_word_addr,
    output logic [WORD_W-1:0]   sh_rd_data
);
    localparam int WA_W   = ADDR_W - 2;
    localparam int PG_W   = ADDR_W - PAGE_SHIFT;
    localparam int WPP_SH = PAGE_SHIFT - 2;
    localparam int MI_W   = (PG_W > 3) ? PG_W - 3 : 1;
    localparam int MAX_B  = (1 << ADDR_W) + 4 * (1 << PG_W);

    logic              wr_fire;
    logic [PG_W-1:0]   wr_page;
    logic [7:0]        map_byte;
    logic [MI_W-1:0]   map_idx;
    logic              clr_byte_en;
    logic              clr_all;
    logic [WA_W-1:0]   eng_rd_addr;
    logic [WORD_W-1:0] work_rd_data;
    logic              sh_we;
    logic [WA_W-1:0]   sh_waddr;

    assign wr_ready = !sync_busy;
    assign wr_fire  = wr_en && wr_ready;
    assign wr_page  = PG_W'(wr_word_addr >> WPP_SH);

    snap_ram #(.AW(WA_W), .DW(WORD_W)) work_ram_i (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (wr_word_addr),
        .wdata (wr_data),
        .raddr (eng_rd_addr),
        .rdata (work_rd_data)
    );

    snap_ram #(.AW(WA_W), .DW(WORD_W)) shadow_ram_i (
        .clk   (clk),
        .we    (sh_we),
        .waddr (sh_waddr),
        .wdata (work_rd_data),
        .raddr (sh_rd_word_addr),
        .rdata (sh_rd_data)
    );

    snap_dirty_map #(.PG_W(PG_W)) map_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (wr_fire),
        .set_page    (wr_page),
        .clr_byte_en (clr_byte_en),
        .clr_idx     (map_idx),
        .clr_all     (clr_all),
        .rd_idx      (map_idx),
        .rd_byte     (map_byte)
    );

    snap_copy_engine #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CNT_W      (CNT_W)
    ) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_req    (sync_req),
        .sync_whole  (sync_whole),
        .map_byte    (map_byte),
        .map_idx     (map_idx),
        .clr_byte_en (clr_byte_en),
        .clr_all     (clr_all),
        .rd_addr     (eng_rd_addr),
        .sh_we       (sh_we),
        .sh_addr     (sh_waddr),
        .busy        (sync_busy),
        .done        (done_pulse),
        .done_bytes  (done_bytes)
    );
endmodule

// File: rtl/snap_copier_chk.sv
module snap_copier_chk #(
    parameter int CNT_W = 14,
    parameter int MAX_B = 8224
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_req,
    input logic             sync_busy,
    input logic             done_pulse,
    input logic [CNT_W-1:0] done_bytes
);
    a_r9_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_busy) |-> $past(sync_req));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ($past(sync_busy) && !sync_busy));

    a_r10_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_pulse |-> $stable(done_bytes));

    a_r8_count_words: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done_bytes[1:0] == 2'b00));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (int'(done_bytes) <= MAX_B));
endmodule

bind snap_copier snap_copier_chk #(.CNT_W(CNT_W), .MAX_B(MAX_B)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_req   (sync_req),
    .sync_busy  (sync_busy),
    .done_pulse (done_pulse),
    .done_bytes (done_bytes)
);

// File: tb/snap_copier_tb_top.sv
module snap_copier_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int PAGE_SHIFT = 4;
    localparam int CNT_W      = $clog2((1 << ADDR_W) + 4 * (1 << (ADDR_W - PAGE_SHIFT)) + 1);
    localparam int WA_W       = ADDR_W - 2;
    localparam int VEC_N      = 10;

    localparam logic [15:0] V_MASK [VEC_N] = '{
        16'h0000, 16'h0001, 16'h8000, 16'h8001, 16'h0101,
        16'hFFFF, 16'h0000, 16'h00F0, 16'h00F0, 16'h4002};
    localparam bit V_WHOLE [VEC_N] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam int V_EXP [VEC_N] = '{0, 20, 16, 36, 40, 316, 256, 256, 80, 40};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [WA_W-1:0] wr_word_addr = '0;
    logic [31:0] wr_data = '0;
    logic wr_ready;
    logic sync_req = 1'b0;
    logic sync_whole = 1'b0;
    logic sync_busy;
    logic done_pulse;
    logic [CNT_W-1:0] done_bytes;
    logic [WA_W-1:0] sh_rd_word_addr = '0;
    logic [31:0] sh_rd_data;

    int n_checks = 0;
    int n_fail = 0;
    int n_done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snap_copier #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_word_addr    (wr_word_addr),
        .wr_data         (wr_data),
        .wr_ready        (wr_ready),
        .sync_req        (sync_req),
        .sync_whole      (sync_whole),
        .sync_busy       (sync_busy),
        .done_pulse      (done_pulse),
        .done_bytes      (done_bytes),
        .sh_rd_word_addr (sh_rd_word_addr),
        .sh_rd_data      (sh_rd_data)
    );

    always @(negedge clk) if (rst_n && done_pulse) n_done++;

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_word(input int w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_word_addr = WA_W'(w); wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_sync(input logic whole, output int bytes);
        int guard = 0;
        @(negedge clk);
        sync_req = 1'b1; sync_whole = whole;
        @(negedge clk);
        sync_req = 1'b0; sync_whole = 1'b0;
        while (!done_pulse && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        bytes = int'(done_bytes);
        @(negedge clk);
    endtask

    task automatic rd_shadow(input int w, output logic [31:0] d);
        @(negedge clk);
        sh_rd_word_addr = WA_W'(w);
        @(negedge clk);
        d = sh_rd_data;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int b;
        int nd0;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 wr_ready", wr_ready, 1);
        chk("R1 sync_busy", sync_busy, 0);
        chk("R1 done_pulse", done_pulse, 0);
        chk("R1 done_bytes", done_bytes, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R3 R4 R5 R6 R7
        for (int v = 0; v < VEC_N; v++) begin
            for (int p = 0; p < 16; p++) begin
                if (V_MASK[v][p]) write_word(p * 4 + (p % 4), 32'h1000_0000 + v * 256 + p);
            end
            do_sync(V_WHOLE[v], b);
            chk($sformatf("R3/R5/R7 vector %0d", v), b, V_EXP[v]);
        end

        // R6: bitmap empty after an incremental sync
        do_sync(1'b0, b);
        chk("R6 second sync", b, 0);

        // R2: repeated writes to one page count once
        write_word(24, 32'hAAAA_0001);
        write_word(25, 32'hAAAA_0002);
        write_word(24, 32'hAAAA_0003);
        do_sync(1'b0, b);
        chk("R2 same page once", b, 20);

        // R3 data, R11 read latency
        for (int i = 0; i < 4; i++) write_word(8 + i, 32'hA500_0000 + i);
        do_sync(1'b0, b);
        chk("R3 page 2 count", b, 20);
        for (int i = 0; i < 4; i++) begin
            rd_shadow(8 + i, d);
            chk("R3/R11 shadow data", d, 32'hA500_0000 + i);
        end
        rd_shadow(24, d);
        chk("R11 shadow page 6", d, 32'hAAAA_0003);

        // R8 stall, R9 ignored request, R10 single pulse
        for (int p = 0; p < 16; p++) write_word(p * 4, 32'h5500_0000 + p);
        nd0 = n_done;
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        chk("R8 wr_ready low while busy", wr_ready, 0);
        chk("R10 busy high", sync_busy, 1);
        @(negedge clk);
        sync_req = 1'b0;
        write_word(21, 32'hC0FF_EE55);
        chk("R8 write held until done", n_done - nd0, 1);
        repeat (3) @(negedge clk);
        chk("R9 one completion", n_done - nd0, 1);
        chk("R3 full map count", done_bytes, 316);
        chk("R10 pulse low", done_pulse, 0);
        chk("R10 count held", done_bytes, 316);
        do_sync(1'b0, b);
        chk("R8 held write marked", b, 20);
        rd_shadow(21, d);
        chk("R8 held write data", d, 32'hC0FF_EE55);

        // R7 whole clears bitmap
        write_word(2, 32'h7);
        do_sync(1'b1, b);
        chk("R7 whole count", b, 256);
        do_sync(1'b0, b);
        chk("R7 whole cleared map", b, 0);

        summary();
        $finish;
    end
endmodule